// File: doc/BRIEF.md
# Flash Program/Erase Status Readback

This block sits on the read path of a flash memory model, between the storage array and the data bus. While the array controller is idle, a read returns the word that the array presents. While a word program or a sector or chip erase is running, the block replaces array data with a status word. A host can therefore poll any location until the operation ends.

The status word carries two completion indicators at the same time. Bit 7 is a polarity flag: during a program it reads as the inverse of bit 7 of the word being loaded, and during an erase it reads as 0. Bit 6 is a toggle flag that inverts on every new read access for as long as the operation runs. The block registers the read strobe so that each access produces exactly one flip. It also captures the loaded word's bit 7 when the busy period starts, so the polarity flag does not depend on the load data bus later on. The data output and its enable are registered, so they are valid one clock after the bus inputs are sampled.

Top module: `flash_status_readback`

## Requirements
- R1: `dout_en` is 1 in the cycle after a clock edge where `rst_n`=1, `bus_sel`=1, `bus_oe`=1 and `bus_wr`=0. In every other case it is 0 after that edge, which means high impedance.
- R2: A read that is sampled with `busy`=0 returns, one clock later, the `array_data` value sampled at the same edge. This also holds on every further cycle of a read that stays active.
- R3: A read during a program (`busy`=1, `op_kind`=0) returns on bit 7 the inverse of bit 7 of `load_data`.
- R4: A read during an erase (`busy`=1, `op_kind`=1) returns 0 on bit 7.
- R5: While `busy`=1, bit 6 inverts on the first cycle of each new read access (a rising edge of the read condition of R1). It keeps its value across the further cycles of the same access.
- R6: While `busy`=1, every bit of `dout` other than 7 and 6 reads as 0.
- R7: The first read sampled after `busy` falls returns true array data on all 16 bits. This includes a read that stays active across the falling edge of `busy`.
- R8: Read accesses made while `busy`=0 do not advance the toggle state. The first busy read after them shows bit 6 inverted relative to the last busy read.
- R9: Polling may start any number of cycles after `busy` rises, and the first read still returns the correct status word.
- R10: `load_data` is captured at the edge where `busy` rises, and changes to it during the busy period have no effect on bit 7.
- R11: Synchronous reset (`rst_n`=0) clears `dout` to 0, drops `dout_en` and clears the toggle state. With the toggle cleared, the first busy read after reset shows bit 6 = 1. If `busy` is still high when reset is released, that cycle counts as a fresh start of the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also forces the output to high impedance |
| bus_sel | input | 1 | Chip select, active high |
| bus_oe | input | 1 | Output enable, active high |
| bus_wr | input | 1 | Write strobe, active high; blocks reads |
| rd_addr | input | 17 | Read address from the bus |
| busy | input | 1 | Array controller is programming or erasing |
| op_kind | input | 1 | Running operation: 0 = word program, 1 = erase |
| load_data | input | 16 | Word most recently loaded for programming |
| array_data | input | 16 | Word read from the array at `arr_addr` |
| arr_addr | output | 17 | Address forwarded to the array |
| dout | output | 16 | Read data or status word |
| dout_en | output | 1 | Drive enable for `dout`; 0 means high impedance |

## Verification
Every result is due exactly one rising edge after its stimulus, because `dout` and `dout_en` are each one register deep and the toggle and polarity registers feed that register through their next-state values. The bench changes inputs on the falling edge, lets one rising edge pass, and compares at the next falling edge. It keeps its own model of the toggle flag, which it flips only when it starts a read access while `busy` is high. Multi-cycle reads are checked on every cycle, so a second flip within one access would be caught.

// File: rtl/flash_rb_pkg.sv
// Package: shared widths, status bit positions and operation encoding
// for the flash status readback path.
package flash_rb_pkg;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 17;
    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_t;
endpackage

// File: rtl/rb_strobe_edge.sv
// rb_strobe_edge: registers the read condition and reports the first cycle
// of each read access. Assumes rd_req is synchronous to clk.
module rb_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    output logic rd_start
);
    logic rd_q;

    // Remember whether a read was active at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_req;
    end

    // A new access begins where the read condition rises.
    always_comb rd_start = rd_req & ~rd_q;
endmodule

// File: rtl/rb_toggle_track.sv
// rb_toggle_track: holds the toggle flag. It inverts once per read access
// made while busy and is frozen while idle. tog_next is the value that the
// current access must present.
module rb_toggle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_start,
    output logic tog_next
);
    logic tog_q;

    // Next value: flip only when a busy read access begins.
    always_comb tog_next = tog_q ^ (busy & rd_start);

    // Store the flag; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_next;
    end
endmodule

// File: rtl/rb_poll_hold.sv
// rb_poll_hold: captures the polled bit of the loaded word at the edge where
// busy rises and holds it for the whole busy period. Assumes load_bit is
// valid in the cycle busy first goes high.
module rb_poll_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic load_bit,
    output logic pol_bit
);
    logic busy_q;
    logic hold_q;
    logic start;

    // Detect the first cycle of a busy period.
    always_comb start = busy & ~busy_q;

    // Present the fresh bit on the start cycle, the held one afterwards.
    always_comb pol_bit = start ? load_bit : hold_q;

    // Track busy and keep the captured bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            busy_q <= busy;
            hold_q <= pol_bit;
        end
    end
endmodule

// File: rtl/rb_status_word.sv
// rb_status_word: builds the status word shown while busy. The polarity flag
// is the inverted captured bit for a program and 0 for an erase. The toggle
// flag is placed on its own bit, and every other bit is 0.
module rb_status_word
    import flash_rb_pkg::*;
(
    input  op_kind_t          op,
    input  logic              pol_bit,
    input  logic              tog,
    output logic [DATA_W-1:0] word
);
    // Assemble the status word bit by bit.
    always_comb begin
        word             = '0;
        word[POLL_BIT]   = (op == OP_PROGRAM) ? ~pol_bit : 1'b0;
        word[TOGGLE_BIT] = tog;
    end
endmodule

// File: rtl/flash_status_readback.sv
// flash_status_readback: read-path multiplexer of the flash model. It
// returns array data while idle and a polling status word while a program or
// erase runs. Output data and enable are registered one cycle after the bus
// inputs are sampled. Assumes all inputs are synchronous to clk.
module flash_status_readback
    import flash_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_oe,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy,
    input  logic              op_kind,
    input  logic [DATA_W-1:0] load_data,
    input  logic [DATA_W-1:0] array_data,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    logic              rd_req;
    logic              rd_start;
    logic              tog_next;
    logic              pol_bit;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] dout_q;
    logic              en_q;

    // Read condition: selected, output enabled, no write strobe.
    always_comb rd_req = bus_sel & bus_oe & ~bus_wr;

    // The array is addressed straight from the bus.
    always_comb arr_addr = rd_addr;

    rb_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_start (rd_start)
    );

    rb_toggle_track u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .rd_start (rd_start),
        .tog_next (tog_next)
    );

    rb_poll_hold u_pol (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .load_bit (load_data[POLL_BIT]),
        .pol_bit  (pol_bit)
    );

    rb_status_word u_word (
        .op      (op_kind_t'(op_kind)),
        .pol_bit (pol_bit),
        .tog     (tog_next),
        .word    (status)
    );

    // Output register: status while busy, array data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
            en_q   <= 1'b0;
        end else begin
            dout_q <= busy ? status : array_data;
            en_q   <= rd_req;
        end
    end

    assign dout    = dout_q;
    assign dout_en = en_q;
endmodule

// File: rtl/flash_status_readback_chk.sv
// flash_status_readback_chk: port-level properties of the readback path,
// bound to every instance of the top module.
module flash_status_readback_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_oe,
    input logic        bus_wr,
    input logic        busy,
    input logic        op_kind,
    input logic [15:0] array_data,
    input logic [15:0] dout,
    input logic        dout_en
);
    logic rd;
    logic armed_q;
    logic prev_busy_rd_q;

    always_comb rd = bus_sel & bus_oe & ~bus_wr;

    // Track one cycle out of reset and whether the last cycle was a busy read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q        <= 1'b0;
            prev_busy_rd_q <= 1'b0;
        end else begin
            armed_q        <= 1'b1;
            prev_busy_rd_q <= busy & rd;
        end
    end

    assert_reset_hiz_R1: assert property (@(posedge clk)
        !rst_n |=> !dout_en);

    assert_noread_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !dout_en);

    assert_idle_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !busy) |=> (dout_en && dout == $past(array_data)));

    assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && busy && op_kind) |=> !dout[7]);

    assert_busy_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && busy) |=> ((dout & 16'hFF3F) == 16'h0000));

    assert_toggle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && prev_busy_rd_q && rd && busy) |=> $stable(dout[6]));
endmodule

bind flash_status_readback flash_status_readback_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_oe     (bus_oe),
    .bus_wr     (bus_wr),
    .busy       (busy),
    .op_kind    (op_kind),
    .array_data (array_data),
    .dout       (dout),
    .dout_en    (dout_en)
);

// File: tb/sim_flash_status_readback.sv
module sim_flash_status_readback;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_oe = 1'b0;
    logic        bus_wr = 1'b0;
    logic [16:0] rd_addr = '0;
    logic        busy = 1'b0;
    logic        op_kind = 1'b0;
    logic [15:0] load_data = '0;
    logic [15:0] array_data = '0;
    logic [16:0] arr_addr;
    logic [15:0] dout;
    logic        dout_en;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    bit  tog_m = 1'b0;
    bit  pol_m = 1'b0;

    always #2 clk = ~clk;

    flash_status_readback u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_oe(bus_oe),
        .bus_wr(bus_wr), .rd_addr(rd_addr), .busy(busy), .op_kind(op_kind),
        .load_data(load_data), .array_data(array_data), .arr_addr(arr_addr),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [16:0] act, logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] stat(bit erase, bit pol, bit tog);
        logic [15:0] w = '0;
        w[7] = erase ? 1'b0 : ~pol;
        w[6] = tog;
        return w;
    endfunction

    task automatic read_on();
        bus_sel = 1; bus_oe = 1; bus_wr = 0;
    endtask

    task automatic read_off();
        bus_sel = 0; bus_oe = 0;
    endtask

    // Start a busy period; the loaded bit is captured at the next edge.
    task automatic start_busy(bit erase, logic [15:0] ld);
        op_kind = erase; load_data = ld; busy = 1; pol_m = ld[7];
        tick();
    endtask

    // One busy read access of len cycles; each cycle is checked.
    task automatic busy_read(string req, int len);
        read_on();
        tog_m = ~tog_m;
        for (int i = 0; i < len; i++) begin
            tick();
            check(req, {dout_en, dout}, {1'b1, stat(op_kind, pol_m, tog_m)});
        end
        read_off();
        tick();
    endtask

    task automatic t_reset();
        rst_n = 0; read_on(); busy = 1;
        tick(); tick();
        check("R11 reset", {dout_en, dout}, 17'h0);
        check("R1 reset hiz", {16'h0, dout_en}, 17'h0);
        read_off(); busy = 0;
        rst_n = 1; tog_m = 0;
        tick();
    endtask

    task automatic t_enable();
        array_data = 16'h1357;
        bus_sel = 1; bus_oe = 1; bus_wr = 1; tick();
        check("R1 write blocks", {16'h0, dout_en}, 17'h0);
        bus_sel = 0; bus_wr = 0; tick();
        check("R1 no select", {16'h0, dout_en}, 17'h0);
        bus_sel = 1; bus_oe = 0; tick();
        check("R1 no oe", {16'h0, dout_en}, 17'h0);
        read_off(); tick();
    endtask

    task automatic t_idle();
        rd_addr = 17'h0ABCD; array_data = 16'hA5C3; read_on(); tick();
        check("R2 idle data", {dout_en, dout}, {1'b1, 16'hA5C3});
        check("R2 addr", arr_addr, 17'h0ABCD);
        array_data = 16'h00FF; tick();
        check("R2 held read", {dout_en, dout}, {1'b1, 16'h00FF});
        read_off(); tick();
        check("R1 release", {16'h0, dout_en}, 17'h0);
    endtask

    task automatic t_program();
        start_busy(0, 16'h1280);
        load_data = 16'h0000;               // R10: must be ignored
        for (int i = 0; i < 5; i++) tick(); // R9: late polling start
        busy_read("R3 R9 R10 program poll", 3);
        busy_read("R5 R6 second access", 1);
        busy_read("R5 third access", 2);
    endtask

    task automatic t_complete();
        array_data = 16'hBEEF; read_on(); tick();
        check("R5 read before end", {dout_en, dout},
              {1'b1, stat(op_kind, pol_m, ~tog_m)});
        tog_m = ~tog_m;
        busy = 0; tick();
        check("R7 completion in-read", {dout_en, dout}, {1'b1, 16'hBEEF});
        read_off(); tick();
        read_on(); array_data = 16'h4411; tick();
        check("R7 true data", {dout_en, dout}, {1'b1, 16'h4411});
        read_off(); tick();
        read_on(); tick(); read_off(); tick();
    endtask

    task automatic t_erase();
        start_busy(1, 16'h00FF);
        busy_read("R4 R8 erase poll", 2);
        busy_read("R4 R5 erase second", 1);
        busy = 0; tick();
    endtask

    task automatic t_program_low();
        start_busy(0, 16'hFF7F);
        busy_read("R3 bit7 low", 1);
        busy_read("R3 R6 bit7 low again", 1);
        busy = 0; tick();
    endtask

    task automatic t_reset_midbusy();
        start_busy(0, 16'h0080);
        busy_read("R3 before reset", 1);
        rst_n = 0; read_on(); tick();
        check("R11 reset mid busy", {dout_en, dout}, 17'h0);
        read_off(); load_data = 16'h0000; rst_n = 1;
        pol_m = 0; tog_m = 0;
        tick();
        busy_read("R11 toggle cleared", 1);
        busy = 0; tick();
    endtask

    initial begin
        tick();
        t_reset();
        t_enable();
        t_idle();
        t_program();
        t_complete();
        t_erase();
        t_program_low();
        t_reset_midbusy();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule